// File: doc/BRIEF.md
# Timer Event Status Register with Read-Armed Clearing

This block holds the two event flags of one general-purpose timer and presents them to software as a 16-bit register on a simple synchronous register bus. The timer core sends two single-cycle pulses, one per event kind. A capture pulse sets the capture flag, and a compare pulse sets the compare flag. Each flag stays set until software clears it. The block also raises a registered interrupt request while any flag whose enable input is high is set.

Clearing a flag takes two steps. Software must first read the register and see the flag at 1. It then writes 0 to that bit. Each flag has a hidden arm bit. A read that returns 1 for the flag sets its arm bit. Any register write clears every arm bit, and a new event on a flag clears that flag's arm bit. So an event that lands between the read and the write always needs a fresh read, and it cannot be dropped without being seen. Two copies of the block serve two timers.

Top module: `tmr_evt_status`

## Requirements
- R1: After reset, a selected read returns 0x0000 and `irq` is low.
- R2: A `capPulse` sets the capture flag, which is bit 1. A `cmpPulse` sets the compare flag, which is bit 0. A set flag stays set until an armed clear removes it.
- R3: Bits 15 to 2 always read as 0. Writes to those bits are ignored, and writing 1 to a flag bit does not change that flag.
- R4: A write of 0 to a flag bit clears that flag if an earlier read returned the flag as 1 and no write or event on that flag has happened since. The flag reads 0 from the next cycle.
- R5: A write of 0 to a flag that has not been read as 1 leaves the flag set.
- R6: An event on a flag that arrives after the arming read and before the write disarms that flag. The following write of 0 leaves the flag set.
- R7: Any register write disarms both flags, whatever value it carries. A second write of 0 without a new read leaves the flags set.
- R8: When an event pulse and an armed clearing write reach the same flag in the same cycle, the flag stays set.
- R9: `irq` is the registered OR of (capture flag AND `capIrqEn`) and (compare flag AND `cmpIrqEn`). It follows those flag and enable values with one cycle of delay.
- R10: `rdData` shows the register contents in the same cycle as a selected read. It is 0x0000 in any cycle with no selected read. A read changes nothing except the arm bits.
- R11: `rdStb` and `wrStb` have no effect while `sel` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, combinational |
| capPulse | input | 1 | Capture event pulse from the timer core |
| cmpPulse | input | 1 | Compare event pulse from the timer core |
| capIrqEn | input | 1 | Interrupt enable for the capture flag |
| cmpIrqEn | input | 1 | Interrupt enable for the compare flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the event inputs are single-cycle pulses that are valid only at clock edges. They also assume that read and write strobes are sampled only together with `sel`. Nothing is assumed about read and write arriving in the same cycle, because the write takes priority there. The random stimulus drives every input each cycle at the falling edge and draws events, reads, writes and enables independently. Write data leans toward 0 so that armed clears happen often. The directed sequences cover the corners of arming, disarming and event collision.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int NUM_FLAGS = 2;
  localparam int CMP_IDX   = 0;
  localparam int CAP_IDX   = 1;

  typedef struct packed {
    logic                 rdHit;
    logic                 wrHit;
    logic [NUM_FLAGS-1:0] clrFlag;
  } evtStrobe_t;
endpackage

// File: rtl/tmr_evt_ctrl.sv
module tmr_evt_ctrl
  import tmr_evt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sel,
  input  logic                 rdStb,
  input  logic                 wrStb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_FLAGS-1:0] flagQ,
  input  logic [NUM_FLAGS-1:0] evtPulse,
  output evtStrobe_t           strb
);
  logic                 rdHit;
  logic                 wrHit;
  logic [NUM_FLAGS-1:0] armQ;

  assign rdHit = sel & rdStb;
  assign wrHit = sel & wrStb;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_arm
    // The write has priority over a read in the same cycle.
    always_ff @(posedge clk) begin
      if (!rstN)             armQ[i] <= 1'b0;
      else if (evtPulse[i])  armQ[i] <= 1'b0;
      else if (wrHit)        armQ[i] <= 1'b0;
      else if (rdHit && flagQ[i]) armQ[i] <= 1'b1;
    end

    assign strb.clrFlag[i] = wrHit & armQ[i] & ~wrData[i];

    // R6
    evt_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[i] |=> !armQ[i]);

    // R4
    arm_implies_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      armQ[i] |-> flagQ[i]);
  end

  assign strb.rdHit = rdHit;
  assign strb.wrHit = wrHit;

  // R7
  write_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> (armQ == '0));
endmodule

// File: rtl/tmr_evt_dpath.sv
module tmr_evt_dpath
  import tmr_evt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  evtStrobe_t           strb,
  input  logic [NUM_FLAGS-1:0] evtPulse,
  input  logic [NUM_FLAGS-1:0] irqEn,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irq
);
  localparam int PAD_W = DATA_W - NUM_FLAGS;

  logic irqQ;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    // An event beats a clear in the same cycle.
    always_ff @(posedge clk) begin
      if (!rstN)                 flagQ[i] <= 1'b0;
      else if (evtPulse[i])      flagQ[i] <= 1'b1;
      else if (strb.clrFlag[i])  flagQ[i] <= 1'b0;
    end

    // R8
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[i] |=> flagQ[i]);

    // R5
    clear_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flagQ[i]) |-> $past(strb.clrFlag[i] && strb.wrHit));
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(flagQ & irqEn);
  end
  assign irq = irqQ;

  assign rdData = strb.rdHit ? {{PAD_W{1'b0}}, flagQ} : '0;

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:NUM_FLAGS] == '0);

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ & irqEn) == '0) |=> !irq);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ & irqEn) != '0) |=> irq);

  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdHit |-> (rdData == '0));
endmodule

// File: rtl/tmr_evt_status.sv
module tmr_evt_status
  import tmr_evt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              capPulse,
  input  logic              cmpPulse,
  input  logic              capIrqEn,
  input  logic              cmpIrqEn,
  output logic              irq
);
  evtStrobe_t           strb;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] evtPulse;
  logic [NUM_FLAGS-1:0] irqEn;

  always_comb begin
    evtPulse          = '0;
    evtPulse[CAP_IDX] = capPulse;
    evtPulse[CMP_IDX] = cmpPulse;
    irqEn             = '0;
    irqEn[CAP_IDX]    = capIrqEn;
    irqEn[CMP_IDX]    = cmpIrqEn;
  end

  tmr_evt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sel(sel), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .flagQ(flagQ), .evtPulse(evtPulse), .strb(strb)
  );

  tmr_evt_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .evtPulse(evtPulse), .irqEn(irqEn),
    .flagQ(flagQ), .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/tmr_evt_status_bench.sv
module tmr_evt_status_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        sel, rdStb, wrStb;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        capPulse, cmpPulse, capIrqEn, cmpIrqEn;
  logic        irq;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycCnt   = 0;

  // bench model: index 0 compare (bit 0), index 1 capture (bit 1)
  logic [1:0] mFlag, mArm;
  logic       mIrq;

  always #5 clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  tmr_evt_status u_tmr_evt_status (
    .clk(clk), .rstN(rstN), .sel(sel), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .rdData(rdData), .capPulse(capPulse), .cmpPulse(cmpPulse),
    .capIrqEn(capIrqEn), .cmpIrqEn(cmpIrqEn), .irq(irq)
  );

  function automatic logic [15:0] expRead(logic s, logic r, logic [1:0] f);
    return (s && r) ? {14'd0, f} : 16'd0;
  endfunction

  function automatic logic nextIrq(logic [1:0] f, logic [1:0] en);
    return |(f & en);
  endfunction

  task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic s, logic r, logic w, logic [15:0] d,
                      logic cap, logic cmp, logic capEn, logic cmpEn);
    logic [1:0] evt;
    @(negedge clk);
    sel = s; rdStb = r; wrStb = w; wrData = d;
    capPulse = cap; cmpPulse = cmp; capIrqEn = capEn; cmpIrqEn = cmpEn;
    #1;
    check16({tag, " rdData"}, rdData, expRead(s, r, mFlag));
    check16({tag, " irq"}, {15'd0, irq}, {15'd0, mIrq});
    @(posedge clk);
    evt  = {cap, cmp};
    mIrq = nextIrq(mFlag, {capEn, cmpEn});
    for (int i = 0; i < 2; i++) begin
      if (evt[i]) begin
        mFlag[i] = 1'b1; mArm[i] = 1'b0;
      end else if (s && w) begin
        if (mArm[i] && !d[i]) mFlag[i] = 1'b0;
        mArm[i] = 1'b0;
      end else if (s && r && mFlag[i]) begin
        mArm[i] = 1'b1;
      end
    end
  endtask

  task automatic rd(string tag);
    step(tag, 1, 1, 0, 16'h0000, 0, 0, capIrqEn, cmpIrqEn);
  endtask
  task automatic wr(string tag, logic [15:0] d);
    step(tag, 1, 0, 1, d, 0, 0, capIrqEn, cmpIrqEn);
  endtask

  initial begin : watchdog
    wait (cycCnt >= 150000);
    failCnt++;
    $display("FAIL watchdog: got %0d cycles expected completion", cycCnt);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_0042);
    sel = 0; rdStb = 0; wrStb = 0; wrData = 0;
    capPulse = 0; cmpPulse = 0; capIrqEn = 1; cmpIrqEn = 1;
    mFlag = 0; mArm = 0; mIrq = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state
    rd("R1");
    // R2 set flags and hold them
    step("R2", 0, 0, 0, 0, 1, 0, 1, 1);
    rd("R2");
    step("R2", 0, 0, 0, 0, 0, 1, 1, 1);
    step("R2", 0, 0, 0, 0, 0, 0, 1, 1);
    // R5 write zero with no read
    wr("R5", 16'h0000);
    rd("R5");
    // R3 ones and upper bits ignored; R7 that write disarms
    wr("R3", 16'hFFFF);
    rd("R3");
    wr("R7", 16'hFFFC);
    wr("R7", 16'h0000);
    rd("R7");
    // R11 strobes without select
    step("R11", 0, 0, 1, 16'h0000, 0, 0, 1, 1);
    rd("R11");
    // R4 armed clear of compare only
    wr("R4", 16'h0002);
    rd("R4");
    wr("R4", 16'h0000);
    rd("R4");
    rd("R4");
    wr("R4", 16'h0000);
    rd("R4");
    // R6 event between read and write
    step("R6", 0, 0, 0, 0, 1, 0, 1, 1);
    rd("R6");
    step("R6", 0, 0, 0, 0, 1, 0, 1, 1);
    wr("R6", 16'h0000);
    rd("R6");
    // R8 event coinciding with armed clear
    step("R8", 1, 1, 0, 0, 0, 0, 1, 1);
    step("R8", 1, 0, 1, 16'h0000, 1, 0, 1, 1);
    rd("R8");
    wr("R8", 16'h0000);
    rd("R8");
    // R9 enable gating and one-cycle lag
    step("R9", 0, 0, 0, 0, 0, 1, 1, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R9", 0, 0, 0, 0, 1, 0, 1, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0);
    // R10 read and write in one cycle: write wins, read data still visible
    step("R10", 1, 1, 1, 16'h0000, 0, 0, 1, 1);
    wr("R10", 16'h0000);
    rd("R10");

    // random mix, checked for R2 R4 R9 R10
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] d;
      d = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0000;
      step("R10 random", $urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 2) == 0, d, $urandom_range(0, 9) == 0,
           $urandom_range(0, 9) == 0, $urandom_range(0, 3) != 0,
           $urandom_range(0, 3) != 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule